// File: doc/BRIEF.md
# Hamming-corrected word memory

This block is a small word memory that keeps every 8-bit data word as a 12-bit single-error-correcting codeword. When a word is written, four check bits are computed and merged with the data. When it is read, the stored codeword is checked again and a 4-bit syndrome is formed. A nonzero syndrome that names one of the twelve codeword positions causes that bit to be inverted before the data is returned, so a single upset anywhere in the codeword is repaired in the response. A syndrome that points past the last position is reported as uncorrectable, and the data bits are then returned as stored.

Requests enter through one valid/ready channel that carries both reads and writes. A read produces one response on a valid/ready response channel one cycle after the request is taken. A write produces no response. The response register holds a single entry. While a response waits with `rsp_ready` low, `req_ready` stays low and no new request is taken, so nothing is dropped. A fault-injection input inverts chosen bits of a stored codeword, which lets a test plant upsets at known positions.

Top module: `hamming_guard_mem`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `rsp_valid` is 0.
- R2: `req_ready` is high whenever no response is pending or `rsp_ready` is high. A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- R3: While `rsp_valid` is high and `rsp_ready` is low, the response fields (`rsp_data`, `rsp_err`, `rsp_uncorr`, `rsp_syndrome`) keep their values and `rsp_valid` stays high.
- R4: A taken write (`req_write`=1) stores the word and produces no response. A taken read raises `rsp_valid` in the next cycle, carrying the word at `req_addr`.
- R5: Codeword bit i-1 holds position i (1 to 12). Check bits sit at positions 1, 2, 4 and 8. Data bit 0 to data bit 7 fill positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order.
- R6: Each check bit makes the count of ones even over the positions whose index has that check bit's weight set. The syndrome is the XOR of the indices of all set positions. A clean word reads back with syndrome 0 and `rsp_err`=0.
- R7: A single flipped data position p gives `rsp_syndrome`=p and `rsp_err`=1, and the returned data equals the written data.
- R8: A single flipped check position (1, 2, 4 or 8) gives `rsp_syndrome` equal to that position, `rsp_err`=1, and unchanged data.
- R9: A syndrome of 13, 14 or 15 sets `rsp_uncorr` and `rsp_err`. The data bits of the stored codeword are returned without any inversion. `rsp_uncorr` is 0 for every other syndrome.
- R10: With `inj_en` high, `inj_mask` is XORed into the codeword at `inj_addr` on the clock edge. If a write to the same address is taken on that edge, the mask applies to the newly written codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 8 | Data to store on a write |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Corrected read data |
| rsp_err | output | 1 | Nonzero syndrome seen |
| rsp_uncorr | output | 1 | Syndrome beyond position 12 |
| rsp_syndrome | output | 4 | Recomputed check value |
| inj_en | input | 1 | Apply fault mask this cycle |
| inj_addr | input | ADDR_W | Word to corrupt |
| inj_mask | input | 12 | Bits to invert, bit i-1 = position i |

## Verification
The assertions watch the handshake on every cycle: a response held under back-pressure, a response one cycle after each taken read and none after a write, and agreement of the error and uncorrectable flags with the syndrome on every response. Whether the syndrome names the right position, whether the repaired bit is the right one, and whether a check-bit hit leaves the data alone can only be shown by the bench's scenarios. In those scenarios every position of a known word and of random words is planted in turn, along with double flips that drive the syndrome past 12, and each result is compared with an independently computed codeword.

// File: rtl/hgm_pkg.sv
package hgm_pkg;
  localparam int DATA_W = 8;
  localparam int CHK_W  = 4;
  localparam int CW_W   = DATA_W + CHK_W;

  typedef logic [CW_W-1:0]   cw_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CHK_W-1:0]  syn_t;

  // position p (1-based) carries a check bit when p is a power of two
  function automatic bit is_chk_pos(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // spread data bits over the non-check positions, check slots left at zero
  function automatic cw_t spread_data(data_t d);
    cw_t c;
    int  k;
    c = '0;
    k = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if (!is_chk_pos(p)) begin
        c[p-1] = d[k];
        k++;
      end
    end
    return c;
  endfunction

  // gather data bits back out of a codeword
  function automatic data_t gather_data(cw_t c);
    data_t d;
    int    k;
    d = '0;
    k = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if (!is_chk_pos(p)) begin
        d[k] = c[p-1];
        k++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/hgm_encoder.sv
module hgm_encoder
  import hgm_pkg::*;
(
  input  data_t din,
  output cw_t   cw
);
  cw_t              base;
  logic [CHK_W-1:0] par;

  assign base = spread_data(din);

  for (genvar b = 0; b < CHK_W; b++) begin : g_par
    logic pb;
    always_comb begin
      pb = 1'b0;
      for (int p = 1; p <= CW_W; p++) begin
        if (p[b]) pb = pb ^ base[p-1];
      end
    end
    assign par[b] = pb;
  end

  always_comb begin
    cw = base;
    for (int b = 0; b < CHK_W; b++) cw[(1 << b) - 1] = par[b];
  end
endmodule

// File: rtl/hgm_decoder.sv
module hgm_decoder
  import hgm_pkg::*;
(
  input  cw_t   raw,
  output data_t data,
  output syn_t  syn,
  output logic  err,
  output logic  uncorr
);
  cw_t flip;

  for (genvar b = 0; b < CHK_W; b++) begin : g_syn
    logic sb;
    always_comb begin
      sb = 1'b0;
      for (int p = 1; p <= CW_W; p++) begin
        if (p[b]) sb = sb ^ raw[p-1];
      end
    end
    assign syn[b] = sb;
  end

  assign err    = (syn != '0);
  assign uncorr = (int'(syn) > CW_W);
  assign flip   = (err && !uncorr) ? (cw_t'(1) << (syn - syn_t'(1))) : '0;
  assign data   = gather_data(raw ^ flip);
endmodule

// File: rtl/hgm_store.sv
module hgm_store
  import hgm_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  cw_t               wcw,
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  cw_t               inj_mask,
  input  logic [ADDR_W-1:0] raddr,
  output cw_t               rcw
);
  cw_t rows [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    cw_t row_q;
    cw_t row_d;
    always_comb begin
      row_d = row_q;
      if (we && waddr == ADDR_W'(i)) row_d = wcw;
      if (inj_en && inj_addr == ADDR_W'(i)) row_d = row_d ^ inj_mask;
    end
    always_ff @(posedge clk) row_q <= row_d;
    assign rows[i] = row_q;
  end

  assign rcw = rows[raddr];
endmodule

// File: rtl/hamming_guard_mem.sv
module hamming_guard_mem
  import hgm_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [hgm_pkg::DATA_W-1:0] req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [hgm_pkg::DATA_W-1:0] rsp_data,
  output logic                    rsp_err,
  output logic                    rsp_uncorr,
  output logic [hgm_pkg::CHK_W-1:0]  rsp_syndrome,
  input  logic                    inj_en,
  input  logic [ADDR_W-1:0]       inj_addr,
  input  logic [hgm_pkg::CW_W-1:0]   inj_mask
);
  logic  take, take_wr, take_rd;
  cw_t   enc_cw, rd_cw;
  data_t dec_data;
  syn_t  dec_syn;
  logic  dec_err, dec_unc;
  logic  valid_q;

  assign req_ready = !valid_q || rsp_ready;
  assign take      = req_valid && req_ready;
  assign take_wr   = take && req_write;
  assign take_rd   = take && !req_write;

  hgm_encoder u_enc (
    .din (req_wdata),
    .cw  (enc_cw)
  );

  hgm_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .we       (take_wr),
    .waddr    (req_addr),
    .wcw      (enc_cw),
    .inj_en   (inj_en),
    .inj_addr (inj_addr),
    .inj_mask (inj_mask),
    .raddr    (req_addr),
    .rcw      (rd_cw)
  );

  hgm_decoder u_dec (
    .raw    (rd_cw),
    .data   (dec_data),
    .syn    (dec_syn),
    .err    (dec_err),
    .uncorr (dec_unc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          valid_q <= 1'b0;
    else if (take_rd)    valid_q <= 1'b1;
    else if (rsp_ready)  valid_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_data     <= '0;
      rsp_err      <= 1'b0;
      rsp_uncorr   <= 1'b0;
      rsp_syndrome <= '0;
    end else if (take_rd) begin
      rsp_data     <= dec_data;
      rsp_err      <= dec_err;
      rsp_uncorr   <= dec_unc;
      rsp_syndrome <= dec_syn;
    end
  end

  assign rsp_valid = valid_q;
endmodule

// File: rtl/hgm_checker.sv
module hgm_checker #(
  parameter int ADDR_W = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [7:0]  rsp_data,
  input logic        rsp_err,
  input logic        rsp_uncorr,
  input logic [3:0]  rsp_syndrome
);
  // R1: reset empties the response slot
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid);

  // R2: an empty slot always accepts
  a_r2_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  // R3: a stalled response does not move
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_syndrome)
                               && $stable(rsp_err) && $stable(rsp_uncorr));

  // R4: a read yields a response on the next cycle
  a_r4_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid);

  // R4: a write yields no response
  a_r4_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> !rsp_valid);

  // R6: error flag tracks a nonzero syndrome
  a_r6_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_err == (rsp_syndrome != 4'd0)));

  // R9: uncorrectable exactly for syndromes past position 12
  a_r9_uncorr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_uncorr == (rsp_syndrome > 4'd12)));
endmodule

bind hamming_guard_mem hgm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_data     (rsp_data),
  .rsp_err      (rsp_err),
  .rsp_uncorr   (rsp_uncorr),
  .rsp_syndrome (rsp_syndrome)
);

// File: tb/sim_hamming_guard_mem.sv
`timescale 1ns/1ps
module sim_hamming_guard_mem;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [7:0]    rsp_data;
  logic          rsp_err;
  logic          rsp_uncorr;
  logic [3:0]    rsp_syndrome;
  logic          inj_en = 1'b0;
  logic [AW-1:0] inj_addr = '0;
  logic [11:0]   inj_mask = '0;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  bit    live = 1'b0;
  string cur_tag = "R4";

  always #2.5 clk = ~clk;

  hamming_guard_mem #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .rsp_uncorr(rsp_uncorr), .rsp_syndrome(rsp_syndrome),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask)
  );

  // ---------------- reference model ----------------
  bit [12:1] shadow [DEPTH];
  bit        m_valid = 1'b0;
  bit [7:0]  m_data;
  bit [3:0]  m_syn;
  bit        m_err, m_unc;

  function automatic bit is_chk(int j);
    return j == 1 || j == 2 || j == 4 || j == 8;
  endfunction

  function automatic bit [12:1] ref_enc(bit [7:0] d);
    bit [12:1] c;
    int k, s;
    c = '0; k = 0; s = 0;
    for (int j = 1; j <= 12; j++) begin
      if (!is_chk(j)) begin
        c[j] = d[k];
        if (d[k]) s = s ^ j;
        k++;
      end
    end
    c[1] = s[0]; c[2] = s[1]; c[4] = s[2]; c[8] = s[3];
    return c;
  endfunction

  task automatic ref_dec(input bit [12:1] c_in, output bit [7:0] d,
                         output bit [3:0] syn, output bit e, output bit u);
    bit [12:1] c;
    int s, k;
    c = c_in; s = 0; k = 0;
    for (int j = 1; j <= 12; j++) if (c[j]) s = s ^ j;
    syn = s[3:0];
    e = (s != 0);
    u = (s > 12);
    if (s >= 1 && s <= 12) c[s] = ~c[s];
    d = '0;
    for (int j = 1; j <= 12; j++) begin
      if (!is_chk(j)) begin
        d[k] = c[j];
        k++;
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 1'b0;
    end else begin
      bit acc;
      acc = req_valid && (!m_valid || rsp_ready);
      if (acc && !req_write) begin
        ref_dec(shadow[req_addr], m_data, m_syn, m_err, m_unc);
        m_valid = 1'b1;
      end else if (rsp_ready) begin
        m_valid = 1'b0;
      end
      if (acc && req_write) shadow[req_addr] = ref_enc(req_wdata);
      if (inj_en) shadow[inj_addr] = shadow[inj_addr] ^ inj_mask;
    end
  end

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare on every clock, just after the falling edge
  always @(negedge clk) begin
    #1;
    if (live && rst_n) begin
      chk("R2", int'(req_ready), int'(!m_valid || rsp_ready), "req_ready");
      chk("R4", int'(rsp_valid), int'(m_valid), "rsp_valid");
      if (m_valid) begin
        string t;
        t = rsp_ready ? cur_tag : "R3";
        chk(t, int'(rsp_data), int'(m_data), "rsp_data");
        chk(t, int'(rsp_syndrome), int'(m_syn), "rsp_syndrome");
        chk(t, int'(rsp_err), int'(m_err), "rsp_err");
        chk(t, int'(rsp_uncorr), int'(m_unc), "rsp_uncorr");
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic send(bit w, bit [AW-1:0] a, bit [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic corrupt(bit [AW-1:0] a, bit [11:0] m);
    @(negedge clk);
    inj_en = 1'b1; inj_addr = a; inj_mask = m;
    @(negedge clk);
    inj_en = 1'b0; inj_mask = '0;
  endtask

  task automatic flip_test(bit [AW-1:0] a, bit [7:0] d, int pos);
    cur_tag = is_chk(pos) ? "R8" : "R7";
    send(1'b1, a, d);
    corrupt(a, 12'(1) << (pos - 1));
    send(1'b0, a, 8'h00);
  endtask

  task automatic double_test(string tag, bit [AW-1:0] a, bit [7:0] d, int p1, int p2);
    cur_tag = tag;
    send(1'b1, a, d);
    corrupt(a, (12'(1) << (p1 - 1)) | (12'(1) << (p2 - 1)));
    send(1'b0, a, 8'h00);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    repeat (4) @(negedge clk);
    chk("R1", int'(rsp_valid), 0, "rsp_valid in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(rsp_valid), 0, "rsp_valid after reset");
    chk("R2", int'(req_ready), 1, "req_ready after reset");
    live = 1'b1;

    // R4: plain writes then reads
    cur_tag = "R4";
    for (int i = 0; i < 4; i++) send(1'b1, AW'(i), 8'($urandom));
    for (int i = 0; i < 4; i++) send(1'b0, AW'(i), 8'h00);

    // R6: clean codeword
    cur_tag = "R6";
    send(1'b1, 4'd5, 8'hC4);
    send(1'b0, 4'd5, 8'h00);
    chk("R6", int'(rsp_syndrome), 0, "clean syndrome");

    // R7 / R8: every single position on a fixed word
    for (int p = 1; p <= 12; p++) flip_test(4'd5, 8'hC4, p);
    // R7 / R8: random words and addresses
    for (int n = 0; n < 24; n++) flip_test(AW'($urandom), 8'($urandom), 1 + int'($urandom % 12));

    // R9: double flips that land beyond position 12
    double_test("R9", 4'd7, 8'h5A, 6, 11);
    double_test("R9", 4'd7, 8'h3C, 2, 12);
    double_test("R9", 4'd7, 8'hA5, 7, 8);
    // R5: flips at positions 3 and 12 expose data bits 0 and 7 raw (C4 -> 45)
    double_test("R5", 4'd9, 8'hC4, 3, 12);
    chk("R5", int'(rsp_data), 8'h45, "layout data");

    // R10: write and inject on the same edge
    cur_tag = "R10";
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd3; req_wdata = 8'h96;
    inj_en = 1'b1; inj_addr = 4'd3; inj_mask = 12'(1) << 6;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; inj_en = 1'b0; inj_mask = '0;
    send(1'b0, 4'd3, 8'h00);
    chk("R10", int'(rsp_syndrome), 7, "inject with write");

    // R3: back-pressure with a second request waiting
    cur_tag = "R3";
    send(1'b1, 4'd11, 8'h71);
    send(1'b1, 4'd12, 8'h18);
    @(negedge clk);
    rsp_ready = 1'b0;
    send(1'b0, 4'd11, 8'h00);
    fork
      send(1'b0, 4'd12, 8'h00);
      begin
        repeat (4) @(negedge clk);
        chk("R3", int'(rsp_data), 8'h71, "held data");
        chk("R2", int'(req_ready), 0, "ready while stalled");
        rsp_ready = 1'b1;
      end
    join
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule